// File: doc/BRIEF.md
# Buffered Modulo Timer with Overflow Interrupt

This block is an up-counting timer on a small 32-bit register port. A control register picks the counter clock, sets a power-of-two prescaler, enables the overflow interrupt and holds the overflow flag. The 16-bit counter starts from a programmable start value, climbs one step per prescaled tick until it equals the limit value, and then goes back to the start value on the next tick. That same tick sets the overflow flag. The interrupt line is high while both the flag and its enable are set.

The start and limit registers have two copies each. A bus write lands in a shadow copy. The shadow is copied to the active value only while the counter clock is off, so software can stage a new period while the timer runs and apply it when it next stops. Writing any value to the counter register loads the active start value into the counter, which makes a clean restart. To get a period of N ticks, program limit = start + N − 1.

Top module: `bmt_timer`

## Requirements
- R1: The registers sit at word addresses 0 (control), 1 (counter), 2 (start) and 3 (limit). The control fields are: clock select in bits 1:0, prescale exponent in bits 4:2, interrupt enable in bit 5 and overflow flag in bit 6. After reset, control, counter and start read 0, limit reads 0xFFFF and the interrupt output is 0. Read data appears one cycle after the address is presented.
- R2: The counter advances only while clock select equals 1. With prescale exponent p, it makes one step every 2^p cycles of that state. Clock-select values 0, 2 and 3 hold the counter. The prescale divider is cleared whenever clock select is not 1.
- R3: Each tick adds one to the counter until the counter equals the active limit. The following tick loads the active start value instead of wrapping through zero.
- R4: The overflow flag (control bit 6) becomes 1 on the tick that moves the counter from the limit to the start value.
- R5: A write of any data to the counter register loads the counter with the active start value. This write takes priority over a tick in the same cycle. Reads of the counter return zero in bits 31:16.
- R6: Writes to start and limit go to shadow copies. Each shadow is copied to its active value only on cycles where clock select equals 0. Reads of start and limit return the active value.
- R7: Writing 0 to control bit 6 clears the overflow flag, and writing 1 leaves it unchanged. If the flag is set and cleared in the same cycle, it is set.
- R8: The interrupt output equals the interrupt enable ANDed with the overflow flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also the counter clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 2 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for bus_addr |
| irq_o | output | 1 | Overflow interrupt, registered |

## Verification
The assertions assume the bus supplies a write strobe with a stable address and data. They also take the start value to be at or below the limit whenever the counter runs, so that the counter only ever sees the increment-then-reload path. The stimulus keeps every configuration in that range, with start 5 and limit 9 in the main sweep and start 0xFFFC with limit 0xFFFF at the top of the range. It also stops the clock before it reads back any count, so each expected value follows directly from the number of enabled cycles.

// File: rtl/bmt_pkg.sv
package bmt_pkg;
  typedef enum logic [1:0] {
    A_CTRL  = 2'd0,
    A_COUNT = 2'd1,
    A_START = 2'd2,
    A_LIMIT = 2'd3
  } bmt_addr_e;

  localparam int unsigned CS_W   = 2;
  localparam logic [1:0]  CS_OFF = 2'd0;
  localparam logic [1:0]  CS_SYS = 2'd1;
endpackage

// File: rtl/bmt_prescaler.sv
module bmt_prescaler #(
  parameter int unsigned PS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [PS_W-1:0] ps,
  output logic            tick
);
  localparam int unsigned DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] pdiv;
  logic [DIV_W-1:0] mask;

  assign mask = ~({DIV_W{1'b1}} << ps);
  assign tick = en && ((pdiv & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || !en) pdiv <= '0;
    else            pdiv <= pdiv + 1'b1;
  end
endmodule

// File: rtl/bmt_shadow.sv
module bmt_shadow #(
  parameter int unsigned W       = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         load,
  output logic [W-1:0] active
);
  logic [W-1:0] shadow;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= RST_VAL;
      active <= RST_VAL;
    end else begin
      if (wr)   shadow <= wdata;
      if (load) active <= shadow;
    end
  end
endmodule

// File: rtl/bmt_counter.sv
module bmt_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         reload,
  input  logic [W-1:0] start,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  assign wrap = tick && !reload && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst)         cnt <= '0;
    else if (reload) cnt <= start;
    else if (wrap)   cnt <= start;
    else if (tick)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/bmt_timer.sv
module bmt_timer #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PS_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  import bmt_pkg::*;

  localparam int unsigned PS_LSB   = CS_W;
  localparam int unsigned IE_BIT   = PS_LSB + PS_W;
  localparam int unsigned FLAG_BIT = IE_BIT + 1;

  logic [CS_W-1:0] csel_q;
  logic [PS_W-1:0] ps_q;
  logic            ie_q, flag_q;
  logic            ie_nxt, flag_nxt;
  logic            ctrl_wr, cnt_wr, start_wr, limit_wr;
  logic            tick, wrap, copy_en;
  logic [CNT_W-1:0] cnt, start_act, limit_act;
  logic [DATA_W-1:0] rd_mux;
  logic            unused_wbits;

  assign unused_wbits = ^bus_wdata[DATA_W-1:CNT_W];

  assign ctrl_wr  = bus_wr && (bus_addr == A_CTRL);
  assign cnt_wr   = bus_wr && (bus_addr == A_COUNT);
  assign start_wr = bus_wr && (bus_addr == A_START);
  assign limit_wr = bus_wr && (bus_addr == A_LIMIT);
  assign copy_en  = (csel_q == CS_OFF);

  bmt_prescaler #(.PS_W(PS_W)) u_pre (
    .clk(clk), .rst(rst), .en(csel_q == CS_SYS), .ps(ps_q), .tick(tick)
  );

  bmt_shadow #(.W(CNT_W), .RST_VAL('0)) u_start (
    .clk(clk), .rst(rst), .wr(start_wr), .wdata(bus_wdata[CNT_W-1:0]),
    .load(copy_en), .active(start_act)
  );

  bmt_shadow #(.W(CNT_W), .RST_VAL({CNT_W{1'b1}})) u_limit (
    .clk(clk), .rst(rst), .wr(limit_wr), .wdata(bus_wdata[CNT_W-1:0]),
    .load(copy_en), .active(limit_act)
  );

  bmt_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .reload(cnt_wr),
    .start(start_act), .limit(limit_act), .cnt(cnt), .wrap(wrap)
  );

  always_comb begin
    ie_nxt   = ctrl_wr ? bus_wdata[IE_BIT] : ie_q;
    flag_nxt = flag_q;
    if (ctrl_wr && !bus_wdata[FLAG_BIT]) flag_nxt = 1'b0;
    if (wrap)                            flag_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csel_q <= CS_OFF;
      ps_q   <= '0;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        csel_q <= bus_wdata[CS_W-1:0];
        ps_q   <= bus_wdata[PS_LSB +: PS_W];
      end
      ie_q   <= ie_nxt;
      flag_q <= flag_nxt;
      irq_o  <= ie_nxt && flag_nxt;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_CTRL: begin
        rd_mux[CS_W-1:0]         = csel_q;
        rd_mux[PS_LSB +: PS_W]   = ps_q;
        rd_mux[IE_BIT]           = ie_q;
        rd_mux[FLAG_BIT]         = flag_q;
      end
      A_COUNT: rd_mux[CNT_W-1:0] = cnt;
      A_START: rd_mux[CNT_W-1:0] = start_act;
      default: rd_mux[CNT_W-1:0] = limit_act;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/bmt_timer_chk.sv
module bmt_timer_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             irq,
  input logic             ie,
  input logic             flag,
  input logic [1:0]       csel,
  input logic             tick,
  input logic             wrap,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] start_act,
  input logic [CNT_W-1:0] limit_act
);
  p_irq_r8: assert property (@(posedge clk) disable iff (rst)
    irq == (ie && flag));

  p_tick_gate_r2: assert property (@(posedge clk) disable iff (rst)
    (csel != 2'd1) |-> !tick);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!tick && !cnt_wr) |=> $stable(cnt));

  p_reload_r3: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt == $past(start_act)));

  p_flag_set_r4: assert property (@(posedge clk) disable iff (rst)
    wrap |=> flag);

  p_load_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> (cnt == $past(start_act)));

  p_shadow_r6: assert property (@(posedge clk) disable iff (rst)
    (csel != 2'd0) |=> ($stable(start_act) && $stable(limit_act)));
endmodule

bind bmt_timer bmt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .irq(irq_o), .ie(ie_q), .flag(flag_q),
  .csel(csel_q), .tick(tick), .wrap(wrap), .cnt_wr(cnt_wr),
  .cnt(cnt), .start_act(start_act), .limit_act(limit_act)
);

// File: tb/sim_bmt_timer.sv
module sim_bmt_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  bmt_timer u0 (.clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
                .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o));

  function automatic logic [31:0] cv(int cs, int p, int ie, int fl);
    return 32'((fl << 6) | (ie << 5) | (p << 2) | cs);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic setup(int s0, int m0);
    wr(2'd0, cv(0, 0, 0, 0));
    wr(2'd2, 32'(s0));
    wr(2'd3, 32'(m0));
    idle(2);
    wr(2'd1, 32'hDEAD_0000);
  endtask

  task automatic run(int s0, int m0, int p, int s, int ie);
    logic [31:0] v;
    int t, n;
    setup(s0, m0);
    wr(2'd0, cv(1, p, ie, 0));
    idle(s - 1);
    wr(2'd0, cv(0, p, ie, 1));
    t = s >> p;
    n = m0 - s0 + 1;
    rd(2'd1, v);
    check("R2/R3 count", v, 32'(s0 + (t % n)));
    rd(2'd0, v);
    check("R4 flag", 32'(v[6]), 32'(t >= n));
    check("R8 irq", 32'(irq_o), 32'((ie != 0) && (t >= n)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset values
    check("R1 irq", 32'(irq_o), 32'd0);
    rd(2'd0, v); check("R1 ctrl", v, 32'd0);
    rd(2'd1, v); check("R1 count", v, 32'd0);
    rd(2'd2, v); check("R1 start", v, 32'd0);
    rd(2'd3, v); check("R1 limit", v, 32'h0000_FFFF);

    // R2 R3 R4 R8 sweep over prescale and run length
    for (int p = 0; p < 4; p++)
      for (int s = 1; s <= 24; s++)
        run(5, 9, p, s, s % 2);
    // R3 reload at the top of the counter range
    for (int s = 1; s <= 10; s++) run(16'hFFFC, 16'hFFFF, 0, s, 1);

    // R2 clock select 2 holds the counter
    setup(5, 9);
    wr(2'd0, cv(2, 0, 0, 1));
    idle(10);
    wr(2'd0, cv(0, 0, 0, 1));
    rd(2'd1, v); check("R2 csel2 hold", v, 32'd5);

    // R6 shadow buffers while running, active after stop
    setup(5, 9);
    wr(2'd0, cv(1, 0, 0, 1));
    wr(2'd2, 32'd2);
    wr(2'd3, 32'd12);
    idle(2);
    rd(2'd2, v); check("R6 start held", v, 32'd5);
    rd(2'd3, v); check("R6 limit held", v, 32'd9);
    wr(2'd0, cv(0, 0, 0, 1));
    idle(1);
    rd(2'd2, v); check("R6 start copied", v, 32'd2);
    rd(2'd3, v); check("R6 limit copied", v, 32'd12);

    // R5 counter write loads start, upper bits read zero
    wr(2'd1, 32'hABCD_1234);
    rd(2'd1, v); check("R5 load start", v, 32'd2);
    check("R5 upper zero", 32'(v[31:16]), 32'd0);

    // R7 writing 1 keeps flag, writing 0 clears it
    run(5, 9, 0, 5, 1);
    wr(2'd0, cv(0, 0, 1, 1));
    rd(2'd0, v); check("R7 write1 keeps", 32'(v[6]), 32'd1);
    check("R8 irq set", 32'(irq_o), 32'd1);
    wr(2'd0, cv(0, 0, 1, 0));
    rd(2'd0, v); check("R7 write0 clears", 32'(v[6]), 32'd0);
    check("R8 irq clear", 32'(irq_o), 32'd0);
    wr(2'd0, cv(0, 0, 1, 1));
    rd(2'd0, v); check("R7 write1 no set", 32'(v[6]), 32'd0);

    // R7 set wins over a clear in the same cycle (start 0, limit 1)
    setup(0, 1);
    wr(2'd0, cv(1, 0, 1, 0));
    idle(1);
    wr(2'd0, cv(1, 0, 1, 0));
    wr(2'd0, cv(0, 0, 1, 1));
    rd(2'd0, v); check("R7 set wins", 32'(v[6]), 32'd1);
    rd(2'd1, v); check("R3 count after", v, 32'd1);
    setup(0, 1);
    wr(2'd0, cv(1, 0, 1, 0));
    idle(2);
    wr(2'd0, cv(0, 0, 1, 0));
    rd(2'd0, v); check("R7 later clear", 32'(v[6]), 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule